// File: doc/BRIEF.md
# Dual-Channel Timer Register Front End

This block is the register-side front end of a two-channel timer. It is an APB slave that decodes a 4 KB window. It turns bus writes into single-cycle strobes toward the two counting channels, and it returns the channels' state on reads. The counting logic itself sits in the channels. The front end sees each channel only as a reload value, a current count, a control byte and a raw interrupt flag. It also drives the write strobes and the shared write data.

The window has a few fixed parts. Channel 0 sits at the bottom of the window and channel 1 follows it, with address bit 5 choosing between them. Two test registers near the top of the window can take over the interrupt pins, so that wiring can be checked without running a timer. A short block of constant identification bytes closes the window. Each channel drives its own interrupt pin, and a third pin is the OR of the two.

The APB port has no back-pressure. Every transfer completes in its access phase and no error is ever signalled. The channel-side strobes carry no handshake of their own. A channel has to accept the write data in the cycle its strobe is high.

Top module: `apb_dtimer_regif`

## Requirements
- R1: After reset the test-enable and test-output registers are zero, so each interrupt pin follows its channel's masked status.
- R2: `pready` is always 1 and `pslverr` is always 0, so every transfer completes in its access phase with zero wait states.
- R3: In offsets 0x00–0x3F, bit 5 selects the channel and bits 4:2 select the register. A read at 0x00 or 0x18 returns the channel reload value, 0x04 returns the current count and 0x08 returns the control byte zero-extended. A read at 0x10 returns the raw interrupt flag in bit 0. A read at 0x14 returns in bit 0 the raw flag ANDed with control bit 5 (the interrupt enable).
- R4: A write at 0x00, 0x18 or 0x08 raises, only during its access phase, the reload-and-restart, reload-only or control strobe of the selected channel, with the written word on `ch_wdata`.
- R5: A write at 0x0C raises the selected channel's interrupt-clear strobe for exactly one cycle. Reads at 0x0C, and at 0x1C, return zero.
- R6: The test-enable register at 0xF00 keeps write bit 0 and reads it back in bit 0, with all other bits zero.
- R7: The test-output register at 0xF04 keeps write bits 1:0 (bit 0 for channel 0, bit 1 for channel 1). It is write-only and reads as zero.
- R8: While test-enable is 1, `irq_ch[k]` equals test-output bit k. Otherwise it equals the channel's masked status.
- R9: `irq_any` is 1 exactly when at least one of `irq_ch` is 1.
- R10: The word reads at 0xFD0, 0xFD4, … 0xFFC return, in that order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of any other offset return zero. Writes to them raise no strobe and change no test register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ch_reload | input | 2x32 | Reload value per channel |
| ch_count | input | 2x32 | Current count per channel |
| ch_ctrl | input | 2x8 | Control byte per channel (bit 5 is the interrupt enable) |
| ch_ris | input | 2 | Raw interrupt flag per channel |
| ch_wdata | output | 32 | Write data shared by all strobes |
| ch_load_stb | output | 2 | Reload-and-restart strobe per channel |
| ch_bgload_stb | output | 2 | Reload-only strobe per channel |
| ch_ctrl_stb | output | 2 | Control-write strobe per channel |
| ch_intclr_stb | output | 2 | Interrupt-clear strobe per channel |
| irq_ch | output | 2 | Interrupt per channel |
| irq_any | output | 1 | OR of both channel interrupts |

## Verification
The assertions assume the master follows the APB protocol. That means an access phase with `penable` high always comes after a setup cycle, and no two access phases are ever adjacent. Under that assumption a strobe can never last two cycles, and at most one strobe fires per transfer. The bench drives each transfer as one setup cycle followed by one access cycle and then returns the bus to idle. Its random addresses are word aligned and drawn both from the mapped offsets and from the rest of the window. The channel-side inputs are re-randomized only while the bus is idle.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CTRL_W    = 8;
  localparam int NUM_CH    = 2;
  localparam int INTEN_BIT = 5;
  localparam int ID_NUM    = 12;

  // register index inside a channel slot (address bits 4:2)
  localparam logic [2:0] RI_LOAD   = 3'd0;
  localparam logic [2:0] RI_COUNT  = 3'd1;
  localparam logic [2:0] RI_CTRL   = 3'd2;
  localparam logic [2:0] RI_INTCLR = 3'd3;
  localparam logic [2:0] RI_RIS    = 3'd4;
  localparam logic [2:0] RI_MIS    = 3'd5;
  localparam logic [2:0] RI_BGLOAD = 3'd6;

  // word addresses (byte address >> 2)
  localparam logic [ADDR_W-3:0] WA_TEST_EN  = 10'h3C0;
  localparam logic [ADDR_W-3:0] WA_TEST_OUT = 10'h3C1;
  localparam logic [ADDR_W-3:0] WA_ID_BASE  = 10'h3F4;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h23;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtr_addr_decode.sv
module dtr_addr_decode
  import dtr_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              in_ch_area,
  output logic              ch_idx,
  output logic [2:0]        reg_idx,
  output logic              hit_test_en,
  output logic              hit_id,
  output logic [3:0]        id_idx,
  output logic [N_CH-1:0]   load_stb,
  output logic [N_CH-1:0]   bgload_stb,
  output logic [N_CH-1:0]   ctrl_stb,
  output logic [N_CH-1:0]   intclr_stb,
  output logic              test_en_wr,
  output logic              test_out_wr
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] waddr;
  logic [WA_W-1:0] id_off;
  logic            wr_acc;
  logic [1:0]      unused_low;

  assign unused_low  = paddr[1:0];
  assign waddr       = paddr[ADDR_W-1:2];
  assign wr_acc      = psel & penable & pwrite;
  assign in_ch_area  = (paddr[ADDR_W-1:6] == '0);
  assign ch_idx      = paddr[5];
  assign reg_idx     = paddr[4:2];
  assign hit_test_en = (waddr == WA_TEST_EN);
  assign hit_id      = (waddr >= WA_ID_BASE);
  assign id_off      = waddr - WA_ID_BASE;
  assign id_idx      = id_off[3:0];
  assign test_en_wr  = wr_acc & hit_test_en;
  assign test_out_wr = wr_acc & (waddr == WA_TEST_OUT);

  for (genvar k = 0; k < N_CH; k++) begin : g_stb
    logic sel_k;
    assign sel_k         = wr_acc & in_ch_area & (ch_idx == 1'(k));
    assign load_stb[k]   = sel_k & (reg_idx == RI_LOAD);
    assign bgload_stb[k] = sel_k & (reg_idx == RI_BGLOAD);
    assign ctrl_stb[k]   = sel_k & (reg_idx == RI_CTRL);
    assign intclr_stb[k] = sel_k & (reg_idx == RI_INTCLR);

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      intclr_stb[k] |=> !intclr_stb[k]); // R5
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_stb, bgload_stb, ctrl_stb, intclr_stb, test_en_wr, test_out_wr})); // R4
  AST_STB_ACCESS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !penable |-> ({load_stb, bgload_stb, ctrl_stb, intclr_stb} == '0)); // R4
endmodule

// File: rtl/dtr_id_rom.sv
module dtr_id_rom
  import dtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       idx,
  output logic [DATA_W-1:0] data
);
  assign data = {{(DATA_W-8){1'b0}}, id_byte(idx)};

  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(idx) |-> $stable(data)); // R10
endmodule

// File: rtl/dtr_itest.sv
module dtr_itest
  import dtr_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr,
  input  logic            out_wr,
  input  logic [N_CH-1:0] wbits,
  input  logic [N_CH-1:0] ch_mis,
  output logic            test_en,
  output logic [N_CH-1:0] irq
);
  logic [N_CH-1:0] test_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_en  <= 1'b0;
      test_out <= '0;
    end else begin
      if (en_wr)  test_en  <= wbits[0];
      if (out_wr) test_out <= wbits;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_irq
    assign irq[k] = test_en ? test_out[k] : ch_mis[k];
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(test_en)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |=> $stable(test_out)); // R7
  AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (irq == ch_mis)); // R8
endmodule

// File: rtl/apb_dtimer_regif.sv
module apb_dtimer_regif
  import dtr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [DATA_W-1:0]             pwdata,
  output logic [DATA_W-1:0]             prdata,
  output logic                          pready,
  output logic                          pslverr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ch_reload,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ch_count,
  input  logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
  input  logic [NUM_CH-1:0]             ch_ris,
  output logic [DATA_W-1:0]             ch_wdata,
  output logic [NUM_CH-1:0]             ch_load_stb,
  output logic [NUM_CH-1:0]             ch_bgload_stb,
  output logic [NUM_CH-1:0]             ch_ctrl_stb,
  output logic [NUM_CH-1:0]             ch_intclr_stb,
  output logic [NUM_CH-1:0]             irq_ch,
  output logic                          irq_any
);
  logic              in_ch_area, ch_idx, hit_test_en, hit_id, test_en;
  logic              test_en_wr, test_out_wr;
  logic [2:0]        reg_idx;
  logic [3:0]        id_idx;
  logic [DATA_W-1:0] id_data;
  logic [NUM_CH-1:0] ch_mis;

  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign ch_wdata = pwdata;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_mis
    assign ch_mis[k] = ch_ris[k] & ch_ctrl[k][INTEN_BIT];
  end

  dtr_addr_decode #(.N_CH(NUM_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .in_ch_area(in_ch_area), .ch_idx(ch_idx), .reg_idx(reg_idx),
    .hit_test_en(hit_test_en), .hit_id(hit_id), .id_idx(id_idx),
    .load_stb(ch_load_stb), .bgload_stb(ch_bgload_stb), .ctrl_stb(ch_ctrl_stb),
    .intclr_stb(ch_intclr_stb), .test_en_wr(test_en_wr), .test_out_wr(test_out_wr)
  );

  dtr_id_rom u_id (.clk(clk), .rst_n(rst_n), .idx(id_idx), .data(id_data));

  dtr_itest #(.N_CH(NUM_CH)) u_itest (
    .clk(clk), .rst_n(rst_n), .en_wr(test_en_wr), .out_wr(test_out_wr),
    .wbits(pwdata[NUM_CH-1:0]), .ch_mis(ch_mis), .test_en(test_en), .irq(irq_ch)
  );

  assign irq_any = |irq_ch;

  always_comb begin
    prdata = '0;
    if (in_ch_area) begin
      unique case (reg_idx)
        RI_LOAD, RI_BGLOAD: prdata = ch_reload[ch_idx];
        RI_COUNT:           prdata = ch_count[ch_idx];
        RI_CTRL:            prdata = {{(DATA_W-CTRL_W){1'b0}}, ch_ctrl[ch_idx]};
        RI_RIS:             prdata = {{(DATA_W-1){1'b0}}, ch_ris[ch_idx]};
        RI_MIS:             prdata = {{(DATA_W-1){1'b0}}, ch_mis[ch_idx]};
        default:            prdata = '0;
      endcase
    end else if (hit_test_en) begin
      prdata = {{(DATA_W-1){1'b0}}, test_en};
    end else if (hit_id) begin
      prdata = id_data;
    end
  end

  AST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ch_area && !hit_test_en && !hit_id) |-> (prdata == '0)); // R11
  AST_ANY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ch == '0) |-> !irq_any); // R9
endmodule

// File: tb/apb_dtimer_regif_tb.sv
module apb_dtimer_regif_tb_top;
  logic              clk = 1'b0, rst_n = 1'b0;
  logic              psel = 0, penable = 0, pwrite = 0;
  logic [11:0]       paddr = '0;
  logic [31:0]       pwdata = '0, prdata, ch_wdata;
  logic              pready, pslverr, irq_any;
  logic [1:0][31:0]  ch_reload, ch_count;
  logic [1:0][7:0]   ch_ctrl;
  logic [1:0]        ch_ris, ch_load_stb, ch_bgload_stb, ch_ctrl_stb, ch_intclr_stb, irq_ch;

  int n_chk = 0, n_fail = 0;
  logic       m_en = 0;
  logic [1:0] m_out = 0;

  always #4 clk = ~clk;

  apb_dtimer_regif dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ch_reload(ch_reload), .ch_count(ch_count), .ch_ctrl(ch_ctrl), .ch_ris(ch_ris),
    .ch_wdata(ch_wdata), .ch_load_stb(ch_load_stb), .ch_bgload_stb(ch_bgload_stb),
    .ch_ctrl_stb(ch_ctrl_stb), .ch_intclr_stb(ch_intclr_stb), .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8, 8'h1B, 8'h00,
                           8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int c = a[5];
    if (a < 12'h040) begin
      case (a[4:0])
        5'h00, 5'h18: return ch_reload[c];
        5'h04: return ch_count[c];
        5'h08: return {24'h0, ch_ctrl[c]};
        5'h10: return {31'h0, ch_ris[c]};
        5'h14: return {31'h0, ch_ris[c] & ch_ctrl[c][5]};
        default: return 32'h0;
      endcase
    end
    if (a == 12'hF00) return {31'h0, m_en};
    if (a >= 12'hFD0) return {24'h0, exp_id((a - 12'hFD0) >> 2)};
    return 32'h0;
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] r;
    for (int k = 0; k < 2; k++) r[k] = m_en ? m_out[k] : (ch_ris[k] & ch_ctrl[k][5]);
    return r;
  endfunction

  task automatic check_irq();
    logic [1:0] e = exp_irq();
    check(irq_ch == e, "R8 irq_ch", {30'h0, irq_ch}, {30'h0, e});
    check(irq_any == |e, "R9 irq_any", {31'h0, irq_any}, {31'h0, |e});
  endtask

  task automatic randomize_ch();
    for (int k = 0; k < 2; k++) begin
      ch_reload[k] = $urandom; ch_count[k] = $urandom;
      ch_ctrl[k] = 8'($urandom); ch_ris[k] = 1'($urandom);
    end
  endtask

  // one transfer: setup then access, checked 1 ns after the access-phase drive
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d);
    logic [7:0] e_stb;
    @(negedge clk); psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    #1;
    check({ch_load_stb, ch_bgload_stb, ch_ctrl_stb, ch_intclr_stb} == 0, "R4 no strobe in setup",
          {24'h0, ch_load_stb, ch_bgload_stb, ch_ctrl_stb, ch_intclr_stb}, 0);
    @(negedge clk); penable = 1;
    #1;
    check(pready && !pslverr, "R2 ready/err", {30'h0, pready, pslverr}, 32'h2);
    if (!wr) begin
      check(prdata == exp_rd(a), $sformatf("R3/R5/R6/R7/R10/R11 read @%h", a), prdata, exp_rd(a));
    end else begin
      e_stb = 0;
      if (a < 12'h040) begin
        case (a[4:0])
          5'h00: e_stb[6 + a[5]] = 1;
          5'h18: e_stb[4 + a[5]] = 1;
          5'h08: e_stb[2 + a[5]] = 1;
          5'h0C: e_stb[0 + a[5]] = 1;
          default: ;
        endcase
      end
      check({ch_load_stb, ch_bgload_stb, ch_ctrl_stb, ch_intclr_stb} == e_stb,
            $sformatf("R4/R5/R11 strobes @%h", a),
            {24'h0, ch_load_stb, ch_bgload_stb, ch_ctrl_stb, ch_intclr_stb}, {24'h0, e_stb});
      if (e_stb != 0) check(ch_wdata == d, "R4 wdata", ch_wdata, d);
    end
    @(posedge clk);
    if (wr && a == 12'hF00) m_en = d[0];
    if (wr && a == 12'hF04) m_out = d[1:0];
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    #1;
    check(ch_intclr_stb == 0, "R5 clear strobe one cycle", {30'h0, ch_intclr_stb}, 0);
    check_irq();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] picks [14] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
                                12'h01C, 12'hF00, 12'hF04, 12'hFD0, 12'hFFC, 12'h040, 12'hF08};
    void'($urandom(32'd1234));
    ch_reload = '0; ch_count = '0; ch_ctrl = '0; ch_ris = '0;
    ch_ris = 2'b11; ch_ctrl[0] = 8'h20; ch_ctrl[1] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: test regs cleared, irq from masked status (ch0 enabled, ch1 masked)
    check(irq_ch == 2'b01, "R1 reset irq", {30'h0, irq_ch}, 32'h1);
    rst_n = 1;
    @(negedge clk); #1;
    check(pready && !pslverr, "R2 idle", {30'h0, pready, pslverr}, 32'h2);
    xfer(0, 12'hF00, 0);
    // R10 all identification words
    for (int i = 0; i < 12; i++) xfer(0, 12'(12'hFD0 + 4 * i), 0);
    // R6 / R7 / R8 directed
    xfer(1, 12'hF04, 32'hFFFF_FFFE);   // out = 2'b10
    xfer(1, 12'hF00, 32'hFFFF_FFFF);   // test mode on
    xfer(0, 12'hF00, 0);
    xfer(0, 12'hF04, 0);               // R7 write-only reads zero
    ch_ris = 2'b11; ch_ctrl = '{8'h20, 8'h20};
    @(negedge clk); #1; check_irq();   // R8 override gives 2'b10
    xfer(1, 12'hF04, 0);               // R9 both low
    xfer(1, 12'hF00, 32'h0000_0002);   // bit0 = 0, test off
    xfer(0, 12'hF00, 0);
    // R11 write outside map leaves test regs intact
    xfer(1, 12'h800, 32'hFFFF_FFFF);
    xfer(0, 12'hF00, 0);
    // R3 both channels, every register
    randomize_ch();
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 8; r++) xfer(0, 12'(c * 32 + r * 4), 0);
    // R4 / R5 directed writes on both channels
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 8; r++) xfer(1, 12'(c * 32 + r * 4), $urandom);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      randomize_ch();
      a = ($urandom % 2) ? picks[$urandom % 14] : 12'({$urandom} << 2);
      xfer(1'($urandom), a, $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule